// File: doc/BRIEF.md
# Synchronous PCI Clock Stop Controller

This block produces a set of PCI-rate clock outputs from a free-running master clock at twice the PCI rate, and parks a subset of them low on request. Two outputs groups exist: a bank of stoppable outputs, and a small group of flexible outputs, each of which software can exempt from stopping. The stop request is the AND of an active-low external pin and a software run bit. A low on either one stops the stoppable outputs.

The external pin first passes through a two-flop synchronizer in the master domain. The combined run condition is sampled once per PCI period, at the edge where the internal PCI phase falls. Each output is a registered gate of that phase. Stopping and restarting therefore always fall between pulses. No output ever produces a shortened high pulse, and every output that is running rises on the same master edge.

A byte-wide register port stands in for the management bus. Address 0 holds the software run bit. Reading that bit returns the combined run state, not the stored value. Address 1 holds the free-run bits of the flexible outputs.

Top module: `pci_clk_stop_ctrl`

## Requirements
- R1: While reset is low every output is low. Reading address 0 returns 0x08 with the pin high. Reading address 1 returns 0x00. After reset is released, every output runs.
- R2: A running output is high for one master cycle and low for the next, which gives the master rate divided by 2. All running outputs rise on the same master edge.
- R3: Once the combined run condition (synchronized pin AND stored run bit) is low, every stoppable output is parked low within 4 master cycles and stays low.
- R4: Bit 3 of address 0 reads as the synchronized pin AND the stored run bit. The other bits of address 0 read 0. A pin driven low shows in the readback after exactly two master edges.
- R5: A write to address 0 stores bit 3 as the software run bit. Writing 0 stops the stoppable outputs with the pin high, and writing 1 restarts them. A 1 written while the pin is low is kept and takes effect once the pin rises.
- R6: After the combined run condition rises, the first high pulse on the stoppable outputs starts within 4 master cycles (two PCI periods). That pulse is full width. Flexible outputs that are not free-running rise on the same edge.
- R7: Bit i of address 1 is the free-run bit of flexible output i. When the bit is 1, the output keeps running regardless of the stop condition. When the bit is 0, the output stops and starts together with the stoppable outputs.
- R8: No output ever shows a high level longer than one master cycle. No output goes high in the cycle right after any output was high, including across every stop and restart.
- R9: Addresses 2 and 3 read 0, and writes to them change nothing. Bits of address 1 above the free-run field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Free-running master clock, twice the PCI rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_n | input | 1 | Asynchronous active-low stop request pin |
| reg_wr | input | 1 | Write strobe, captured on the rising master edge |
| reg_addr | input | 2 | Register byte address for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pci_clk_o | output | N_STOP | Stoppable PCI clock outputs |
| pcif_clk_o | output | N_FREE | Flexible PCI clock outputs with per-output free-run |

## Verification
The bench changes the pin and the two registers at both internal phases. It confirms that outputs stop within the allowed window and resume no later than two PCI periods afterwards. A design that gated the clock combinationally, or updated its gate in the high phase, would emit a clipped or stretched pulse, and the edge monitor reports that. A design that read back the stored bit instead of the combined one would report 1 while the pin is low. A design that dropped a synchronizer stage would show the pin in the readback one edge early. Free-run bits are set while the stop is active to catch a mask applied to the wrong output, and writes to the unused addresses catch address aliasing.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 8;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_FREE = 2'd1;
  localparam int unsigned RUN_BIT = 3;
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pcs_regs.sv
module pcs_regs
  import pcs_pkg::*;
#(
  parameter int unsigned N_FREE = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_DATA_W-1:0] wdata,
  input  logic                  run_status,
  output logic                  sw_run,
  output logic [N_FREE-1:0]     free_run,
  output logic [REG_DATA_W-1:0] rdata
);
  logic              ctrl_we;
  logic              free_we;
  logic              sw_run_q;
  logic [N_FREE-1:0] free_q;
  logic              unused_wbits;

  always_comb begin
    ctrl_we = wr_en && (addr == ADDR_CTRL);
    free_we = wr_en && (addr == ADDR_FREE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_run_q <= 1'b1;
      free_q   <= '0;
    end else begin
      if (ctrl_we) sw_run_q <= wdata[RUN_BIT];
      if (free_we) free_q   <= wdata[N_FREE-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata[RUN_BIT]    = run_status;
      ADDR_FREE: rdata[N_FREE-1:0] = free_q;
      default:   rdata = '0;
    endcase
  end

  assign unused_wbits = ^wdata;
  assign sw_run   = sw_run_q;
  assign free_run = free_q;
endmodule

// File: rtl/pcs_gate.sv
module pcs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_q,
  input  logic run_req,
  output logic clk_o
);
  logic en_q, en_d;
  logic out_q, out_d;

  always_comb begin
    en_d  = phase_q ? run_req : en_q;
    out_d = ~phase_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      out_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/pci_clk_stop_ctrl.sv
module pci_clk_stop_ctrl
  import pcs_pkg::*;
#(
  parameter int unsigned N_STOP      = 6,
  parameter int unsigned N_FREE      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_mst,
  input  logic                  rst_n,
  input  logic                  stop_req_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_DATA_W-1:0] reg_wdata,
  output logic [REG_DATA_W-1:0] reg_rdata,
  output logic [N_STOP-1:0]     pci_clk_o,
  output logic [N_FREE-1:0]     pcif_clk_o
);
  logic              rst_sync_n;
  logic              pin_sync;
  logic              sw_run;
  logic              run_all;
  logic [N_FREE-1:0] free_run;
  logic              ph_q, ph_d;

  pcs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk_mst), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  pcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk_mst), .rst_n(rst_sync_n), .d(stop_req_n), .q(pin_sync)
  );

  pcs_regs #(.N_FREE(N_FREE)) u_regs (
    .clk(clk_mst), .rst_n(rst_sync_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .run_status(run_all), .sw_run(sw_run),
    .free_run(free_run), .rdata(reg_rdata)
  );

  always_comb begin
    run_all = pin_sync & sw_run;
    ph_d    = ~ph_q;
  end

  always_ff @(posedge clk_mst or negedge rst_sync_n) begin
    if (!rst_sync_n) ph_q <= 1'b0;
    else             ph_q <= ph_d;
  end

  for (genvar s = 0; s < N_STOP; s++) begin : g_stop
    pcs_gate u_gate (
      .clk(clk_mst), .rst_n(rst_sync_n), .phase_q(ph_q),
      .run_req(run_all), .clk_o(pci_clk_o[s])
    );
  end

  for (genvar f = 0; f < N_FREE; f++) begin : g_flex
    pcs_gate u_gate (
      .clk(clk_mst), .rst_n(rst_sync_n), .phase_q(ph_q),
      .run_req(run_all | free_run[f]), .clk_o(pcif_clk_o[f])
    );
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
  import pcs_pkg::*;
#(
  parameter int unsigned N_STOP = 6,
  parameter int unsigned N_FREE = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run_all,
  input logic                  pin_sync,
  input logic [N_FREE-1:0]     free_run,
  input logic                  reg_wr,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [REG_DATA_W-1:0] reg_wdata,
  input logic [REG_DATA_W-1:0] reg_rdata,
  input logic [N_STOP-1:0]     pci_clk_o,
  input logic [N_FREE-1:0]     pcif_clk_o
);
  logic [2:0] age_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 3'd4)  age_q <= age_q + 3'd1;
  end
  assign ready = (age_q == 3'd4);

  assert_outputs_in_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_clk_o != '0) |-> (pci_clk_o == '1));

  assert_single_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({pci_clk_o, pcif_clk_o} != '0) |=> ({pci_clk_o, pcif_clk_o} == '0));

  assert_park_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !run_all && !$past(run_all, 1) && !$past(run_all, 2) && !$past(run_all, 3))
      |-> (pci_clk_o == '0));

  assert_restart_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && run_all && $past(run_all, 1) && $past(run_all, 2) && $past(run_all, 3))
      |-> (pci_clk_o[0] || $past(pci_clk_o[0])));

  assert_stop_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTRL && !pin_sync) |-> !reg_rdata[RUN_BIT]);

  assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_CTRL && !reg_wdata[RUN_BIT])
      |=> (reg_addr != ADDR_CTRL || !reg_rdata[RUN_BIT]));

  for (genvar i = 0; i < N_FREE; i++) begin : g_flex_chk
    assert_free_keeps_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && free_run[i] && $past(free_run[i], 1) && $past(free_run[i], 2) && $past(free_run[i], 3))
        |-> (pcif_clk_o[i] || $past(pcif_clk_o[i])));

    assert_flex_follows_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !(run_all | free_run[i]) && !$past(run_all | free_run[i], 1)
        && !$past(run_all | free_run[i], 2) && !$past(run_all | free_run[i], 3))
        |-> !pcif_clk_o[i]);
  end
endmodule

bind pci_clk_stop_ctrl pcs_chk #(.N_STOP(N_STOP), .N_FREE(N_FREE)) u_chk (
  .clk(clk_mst), .rst_n(rst_sync_n), .run_all(run_all), .pin_sync(pin_sync),
  .free_run(free_run), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o)
);

// File: tb/pci_clk_stop_ctrl_bench.sv
module pci_clk_stop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_STOP = 6;
  localparam int N_FREE = 3;
  localparam int N_VEC = 10;

  // {pin, wr, addr[1:0], wdata[7:0], exp_run, exp_flex[2:0], exp_readback}
  localparam logic [16:0] VEC [N_VEC] = '{
    {1'b1, 1'b1, 2'd0, 8'h08, 1'b1, 3'b111, 1'b1},
    {1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 3'b000, 1'b0},
    {1'b0, 1'b1, 2'd1, 8'h05, 1'b0, 3'b101, 1'b0},
    {1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 3'b111, 1'b1},
    {1'b1, 1'b1, 2'd0, 8'h00, 1'b0, 3'b101, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'h02, 1'b0, 3'b010, 1'b0},
    {1'b0, 1'b1, 2'd0, 8'h08, 1'b0, 3'b010, 1'b0},
    {1'b1, 1'b1, 2'd1, 8'h00, 1'b1, 3'b111, 1'b1},
    {1'b1, 1'b1, 2'd2, 8'hFF, 1'b1, 3'b111, 1'b1},
    {1'b1, 1'b1, 2'd3, 8'h00, 1'b1, 3'b111, 1'b1}
  };

  logic              clk_mst;
  logic              rst_n;
  logic              stop_req_n;
  logic              reg_wr;
  logic [1:0]        reg_addr;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;
  logic [N_STOP-1:0] pci_clk_o;
  logic [N_FREE-1:0] pcif_clk_o;

  int n_vec = 0;
  int n_bad = 0;
  int cnt_p [N_STOP];
  int cnt_f [N_FREE];
  int mon_viol = 0;
  logic mon_on = 1'b0;
  logic [N_STOP+N_FREE-1:0] prev_all = '0;

  pci_clk_stop_ctrl #(.N_STOP(N_STOP), .N_FREE(N_FREE)) u_pci_clk_stop_ctrl (
    .clk_mst(clk_mst), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o)
  );

  initial clk_mst = 1'b0;
  always #(CLK_PERIOD/2) clk_mst = ~clk_mst;

  // R8 / R2 edge monitor: a high sample must be followed by an all-low sample,
  // and stoppable outputs are either all high or all low.
  always @(negedge clk_mst) begin
    if (mon_on) begin
      if ({pci_clk_o, pcif_clk_o} != '0 && prev_all != '0) mon_viol++;
      if (pci_clk_o != '0 && pci_clk_o != '1) mon_viol++;
    end
    prev_all = {pci_clk_o, pcif_clk_o};
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_mst);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk_mst);
    reg_wr    = 1'b0;
  endtask

  task automatic measure();
    for (int j = 0; j < N_STOP; j++) cnt_p[j] = 0;
    for (int j = 0; j < N_FREE; j++) cnt_f[j] = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_mst);
      for (int j = 0; j < N_STOP; j++) cnt_p[j] += int'(pci_clk_o[j]);
      for (int j = 0; j < N_FREE; j++) cnt_f[j] += int'(pcif_clk_o[j]);
    end
  endtask

  function automatic int state_of(input int c);
    return (c == 2) ? 1 : ((c == 0) ? 0 : 2);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; stop_req_n = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    repeat (4) @(negedge clk_mst);
    // R1: reset state
    chk("R1 outputs low in reset", int'({pci_clk_o, pcif_clk_o}), 0);
    reg_addr = 2'd0; #1;
    chk("R1 ctrl readback in reset", int'(reg_rdata), 8);
    reg_addr = 2'd1; #1;
    chk("R1 free readback in reset", int'(reg_rdata), 0);
    @(negedge clk_mst);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_mst);
    mon_on = 1'b1;
    measure();
    for (int j = 0; j < N_STOP; j++) chk("R1 stoppable runs after reset", state_of(cnt_p[j]), 1);
    for (int j = 0; j < N_FREE; j++) chk("R1 flexible runs after reset", state_of(cnt_f[j]), 1);

    // Vector table: R3 R4 R5 R7 R9 across combinations
    for (int v = 0; v < N_VEC; v++) begin
      @(negedge clk_mst);
      stop_req_n = VEC[v][16];
      if (VEC[v][15]) write_reg(VEC[v][14:13], VEC[v][12:5]);
      repeat (8) @(negedge clk_mst);
      reg_addr = 2'd0; #1;
      chk($sformatf("R4 vec%0d ctrl readback", v), int'(reg_rdata), VEC[v][0] ? 8 : 0);
      measure();
      for (int j = 0; j < N_STOP; j++)
        chk($sformatf("R3/R5 vec%0d stoppable %0d", v, j), state_of(cnt_p[j]), int'(VEC[v][4]));
      for (int j = 0; j < N_FREE; j++)
        chk($sformatf("R7 vec%0d flexible %0d", v, j), state_of(cnt_f[j]), int'(VEC[v][1+j]));
    end

    // R6: restart latency at both internal phases
    for (int d = 0; d < 2; d++) begin
      write_reg(2'd0, 8'h00);
      repeat (6 + d) @(negedge clk_mst);
      chk("R5 stopped before restart", int'(pci_clk_o), 0);
      write_reg(2'd0, 8'h08);
      lat = 1;
      while (pci_clk_o[0] == 1'b0 && lat < 12) begin
        @(negedge clk_mst);
        lat++;
      end
      chk($sformatf("R6 restart latency <= 4 (phase %0d)", d), int'(lat <= 4), 1);
      chk("R6 flexible rise with stoppable", int'(pcif_clk_o), 7);
      chk("R6 all stoppable rise together", int'(pci_clk_o), (1 << N_STOP) - 1);
      @(negedge clk_mst);
      chk("R6 first pulse is one cycle wide", int'({pci_clk_o, pcif_clk_o}), 0);
      @(negedge clk_mst);
      chk("R2 second pulse follows", int'(pci_clk_o), (1 << N_STOP) - 1);
    end

    // R4: pin through two-flop synchronizer; R3 parking
    reg_addr = 2'd0;
    @(negedge clk_mst);
    stop_req_n = 1'b0;
    @(negedge clk_mst);
    chk("R4 readback one edge after pin low", int'(reg_rdata[3]), 1);
    @(negedge clk_mst);
    chk("R4 readback two edges after pin low", int'(reg_rdata[3]), 0);
    repeat (4) @(negedge clk_mst);
    measure();
    for (int j = 0; j < N_STOP; j++) chk("R3 parked low after pin", cnt_p[j], 0);
    stop_req_n = 1'b1;
    repeat (8) @(negedge clk_mst);

    // R9: unused addresses and upper free bits
    write_reg(2'd1, 8'hFF);
    reg_addr = 2'd1; #1;
    chk("R9 upper free bits read 0", int'(reg_rdata), 7);
    reg_addr = 2'd2; #1;
    chk("R9 address 2 reads 0", int'(reg_rdata), 0);
    reg_addr = 2'd3; #1;
    chk("R9 address 3 reads 0", int'(reg_rdata), 0);
    write_reg(2'd1, 8'h00);
    repeat (4) @(negedge clk_mst);

    chk("R8 pulse width and alignment monitor", mon_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule